// File: doc/BRIEF.md
# SDRAM Command Front End

This block is the input stage of a four-bank synchronous DRAM model, seen from the memory side. It samples the select, strobe, write, clock-enable, bank and address pins on every rising clock edge. It turns each valid pin pattern into a one-cycle command strobe that carries a command code, bank index, row and column. It keeps a per-bank open/closed state and the row most recently opened in each bank, and it flags a read or write aimed at a closed bank.

The clock enable acts on the internal clock one cycle late. When the enable is sampled low, the following edge is frozen: commands are not accepted, the bank state holds and the command fields keep their values. If every bank is closed at that moment, the block also reports power-down. The array, data path, refresh counters and mode-register contents belong to other blocks.

Top module: `sdcmd_frontend`

## Requirements
- R1: A command accepted on a rising edge appears after that edge on `cmd_valid` for exactly one cycle, together with its code, bank, row and column. After an edge that accepts no command, `cmd_valid` and `cmd_err` are low and the code, bank, row and column outputs hold their previous values.
- R2: While `sel_n` is high the pins `row_sel_n`, `col_sel_n`, `write_n`, `bank_in` and `addr_in` are ignored: no strobe is produced and no bank state changes.
- R3: With `sel_n` low, {row_sel_n, col_sel_n, write_n} decodes as follows: 011 is open bank (code 1), 101 is read (code 2), 100 is write (code 3), 010 is close (code 4), 001 is refresh (code 5) and 000 is mode set (code 6). The patterns 111 and 110 are no-operations and produce no strobe.
- R4: An open-bank command marks bank `bank_in` active, stores the full 12-bit `addr_in` as that bank's row, and reports that bank and row.
- R5: A read or write reports `bank_in`, the column `addr_in[COL_W-1:0]` and the stored row of that bank. COL_W is 10, 9 or 8 for DATA_W of 4, 8 or 16, and address bits above the column are dropped.
- R6: Close and mode-set commands report `bank_in` with row and column 0. Refresh reports bank 0 with row and column 0.
- R7: A close command with `addr_in[10]` low marks only bank `bank_in` idle. With `addr_in[10]` high it marks all four banks idle.
- R8: A read or write to an idle bank is still reported, and `cmd_err` is high in the same cycle as its strobe.
- R9: When `ck_en` is sampled low on an edge, `frozen` is high after that edge. The next edge accepts no command and changes no bank state, whatever the other pins carry.
- R10: When `ck_en` is sampled low and all banks are idle once that edge's command has been applied, `pdown` is high after the edge. It stays high while `ck_en` stays low. It is never high while a bank is active.
- R11: After `ck_en` is sampled high again, `frozen` and `pdown` drop after that edge, and the very next edge accepts a command.
- R12: Synchronous reset marks all banks idle, clears every output to zero and treats the clock enable as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Chip select, active low |
| row_sel_n | input | 1 | Row strobe, active low |
| col_sel_n | input | 1 | Column strobe, active low |
| write_n | input | 1 | Write enable, active low |
| ck_en | input | 1 | Clock enable |
| bank_in | input | 2 | Bank address |
| addr_in | input | 12 | Multiplexed row/column address |
| cmd_valid | output | 1 | One-cycle strobe for an accepted command |
| cmd_code | output | 3 | Command code (see R3) |
| cmd_bank | output | 2 | Bank of the command |
| cmd_row | output | 12 | Row for open, read and write |
| cmd_col | output | COL_W | Column for read and write |
| cmd_err | output | 1 | Read or write to an idle bank |
| bank_active | output | 4 | Open/closed state per bank |
| frozen | output | 1 | Next edge is suspended |
| pdown | output | 1 | Power-down in effect |

## Verification
On every cycle the assertions check the following: no strobe follows a frozen cycle, bank state is stable across ignored edges, power-down implies frozen with all banks idle, an error flag travels only with a read or write strobe, and open and close commands leave their bank in the matching state. Only the bench scenarios can show the rest. That covers the exact code assignment for each pin pattern, the row and column values carried, truncation of the column, the one-cycle delay of the clock enable on entry and exit, and the choice between suspend and power-down when a bank is opened on the same edge that the enable drops.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int ROW_W  = 12;
    localparam int ADDR_W = 12;
    localparam int BA_W   = 2;
    localparam int NBANK  = 4;
    localparam int AP_BIT = 10;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_MRS = 3'd6
    } cmd_e;

    typedef struct packed {
        cmd_e              code;
        logic [BA_W-1:0]   bank;
        logic [ADDR_W-1:0] addr;
    } req_t;

    function automatic int col_width(input int data_w);
        case (data_w)
            4:       return 10;
            8:       return 9;
            default: return 8;
        endcase
    endfunction

    function automatic cmd_e decode_pins(input logic rs, input logic cs, input logic we);
        case ({rs, cs, we})
            3'b011:  return CMD_ACT;
            3'b101:  return CMD_RD;
            3'b100:  return CMD_WR;
            3'b010:  return CMD_PRE;
            3'b001:  return CMD_REF;
            3'b000:  return CMD_MRS;
            default: return CMD_NOP;
        endcase
    endfunction

endpackage

// File: rtl/sdcmd_clkgate.sv
module sdcmd_clkgate
    import sdcmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ck_en,
    input  logic all_idle_next,
    output logic en,
    output logic frozen,
    output logic pdown
);

    logic cke_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_q <= 1'b1;
            pdown <= 1'b0;
        end else begin
            cke_q <= ck_en;
            pdown <= ~ck_en & all_idle_next;
        end
    end

    assign en     = cke_q;
    assign frozen = ~cke_q;

    AST_PDOWN_FROZEN: assert property (@(posedge clk) disable iff (rst)
        pdown |-> frozen);  // R10

endmodule

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
(
    input  logic              en,
    input  logic              sel_n,
    input  logic              row_sel_n,
    input  logic              col_sel_n,
    input  logic              write_n,
    input  logic [BA_W-1:0]   bank_in,
    input  logic [ADDR_W-1:0] addr_in,
    output req_t              req
);

    always_comb begin
        req.bank = bank_in;
        req.addr = addr_in;
        if (!en || sel_n)
            req.code = CMD_NOP;
        else
            req.code = decode_pins(row_sel_n, col_sel_n, write_n);
    end

endmodule

// File: rtl/sdcmd_banks.sv
module sdcmd_banks
    import sdcmd_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  req_t                        req,
    output logic [NBANK-1:0]            active,
    output logic [NBANK-1:0]            active_next,
    output logic [NBANK-1:0][ROW_W-1:0] rows
);

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic hit;
        assign hit = (req.bank == BA_W'(g));

        always_comb begin
            active_next[g] = active[g];
            if (req.code == CMD_ACT && hit)
                active_next[g] = 1'b1;
            else if (req.code == CMD_PRE && (hit || req.addr[AP_BIT]))
                active_next[g] = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                active[g] <= 1'b0;
                rows[g]   <= '0;
            end else begin
                active[g] <= active_next[g];
                if (req.code == CMD_ACT && hit)
                    rows[g] <= req.addr[ROW_W-1:0];
            end
        end
    end

    AST_BANK_HOLD_NOP: assert property (@(posedge clk) disable iff (rst)
        (req.code == CMD_NOP) |=> $stable(active));  // R9

endmodule

// File: rtl/sdcmd_frontend.sv
module sdcmd_frontend
    import sdcmd_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int COL_W = col_width(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              row_sel_n,
    input  logic              col_sel_n,
    input  logic              write_n,
    input  logic              ck_en,
    input  logic [BA_W-1:0]   bank_in,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              cmd_valid,
    output logic [2:0]        cmd_code,
    output logic [BA_W-1:0]   cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              cmd_err,
    output logic [NBANK-1:0]  bank_active,
    output logic              frozen,
    output logic              pdown
);

    logic                        en;
    req_t                        req;
    logic [NBANK-1:0]            act_next;
    logic [NBANK-1:0][ROW_W-1:0] rows;
    logic                        is_rw;

    sdcmd_clkgate i_gate (
        .clk           (clk),
        .rst           (rst),
        .ck_en         (ck_en),
        .all_idle_next (~|act_next),
        .en            (en),
        .frozen        (frozen),
        .pdown         (pdown)
    );

    sdcmd_decode i_dec (
        .en        (en),
        .sel_n     (sel_n),
        .row_sel_n (row_sel_n),
        .col_sel_n (col_sel_n),
        .write_n   (write_n),
        .bank_in   (bank_in),
        .addr_in   (addr_in),
        .req       (req)
    );

    sdcmd_banks i_banks (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .active      (bank_active),
        .active_next (act_next),
        .rows        (rows)
    );

    assign is_rw = (req.code == CMD_RD) || (req.code == CMD_WR);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid <= 1'b0;
            cmd_code  <= '0;
            cmd_bank  <= '0;
            cmd_row   <= '0;
            cmd_col   <= '0;
            cmd_err   <= 1'b0;
        end else if (req.code == CMD_NOP) begin
            cmd_valid <= 1'b0;
            cmd_err   <= 1'b0;
        end else begin
            cmd_valid <= 1'b1;
            cmd_code  <= req.code;
            cmd_bank  <= (req.code == CMD_REF) ? '0 : req.bank;
            cmd_col   <= is_rw ? req.addr[COL_W-1:0] : '0;
            cmd_err   <= is_rw && !bank_active[req.bank];
            case (req.code)
                CMD_ACT:        cmd_row <= req.addr[ROW_W-1:0];
                CMD_RD, CMD_WR: cmd_row <= rows[req.bank];
                default:        cmd_row <= '0;
            endcase
        end
    end

    AST_NO_STROBE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        frozen |=> !cmd_valid);  // R9

    AST_ERR_WITH_RW: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> cmd_valid && (cmd_code == 3'(CMD_RD) || cmd_code == 3'(CMD_WR)));  // R8

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 3'(CMD_ACT)) |-> bank_active[cmd_bank]);  // R4

    AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 3'(CMD_PRE)) |-> !bank_active[cmd_bank]);  // R7

    AST_PDOWN_IDLE: assert property (@(posedge clk) disable iff (rst)
        pdown |-> (bank_active == '0));  // R10

endmodule

// File: tb/test_sdcmd_frontend.sv
`timescale 1ns/1ps
module test_sdcmd_frontend;

    localparam int CW = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_n = 1'b1, row_sel_n = 1'b1, col_sel_n = 1'b1, write_n = 1'b1, ck_en = 1'b1;
    logic [1:0]  bank_in = '0;
    logic [11:0] addr_in = '0;
    logic        cmd_valid, cmd_err, frozen, pdown;
    logic [2:0]  cmd_code;
    logic [1:0]  cmd_bank;
    logic [11:0] cmd_row;
    logic [CW-1:0] cmd_col;
    logic [3:0]  bank_active;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    logic        m_cke_q = 1'b1;
    logic [3:0]  m_act = '0;
    logic [11:0] m_row [4];
    logic        e_valid = 0, e_err = 0, e_pdown = 0;
    logic [2:0]  e_code = 0;
    logic [1:0]  e_bank = 0;
    logic [11:0] e_row = 0;
    logic [CW-1:0] e_col = 0;

    always #4 clk = ~clk;

    sdcmd_frontend #(.DATA_W(8)) i_sdcmd_frontend (
        .clk(clk), .rst(rst), .sel_n(sel_n), .row_sel_n(row_sel_n),
        .col_sel_n(col_sel_n), .write_n(write_n), .ck_en(ck_en),
        .bank_in(bank_in), .addr_in(addr_in), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .cmd_col(cmd_col), .cmd_err(cmd_err), .bank_active(bank_active),
        .frozen(frozen), .pdown(pdown)
    );

    function automatic logic [2:0] code_of(input logic [2:0] p);
        case (p)
            3'b011: return 3'd1;
            3'b101: return 3'd2;
            3'b100: return 3'd3;
            3'b010: return 3'd4;
            3'b001: return 3'd5;
            3'b000: return 3'd6;
            default: return 3'd0;
        endcase
    endfunction

    task automatic compare(input string tag);
        logic [33:0] act, exp;
        act = {cmd_valid, cmd_code, cmd_bank, cmd_row, cmd_col, cmd_err, bank_active, frozen, pdown};
        exp = {e_valid, e_code, e_bank, e_row, e_col, e_err, m_act, ~m_cke_q, e_pdown};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic s, input logic [2:0] p,
                        input logic k, input logic [1:0] b, input logic [11:0] a);
        logic [2:0] c;
        sel_n = s; {row_sel_n, col_sel_n, write_n} = p; ck_en = k;
        bank_in = b; addr_in = a;
        @(posedge clk);
        c = (m_cke_q && !s) ? code_of(p) : 3'd0;
        if (c != 0) begin
            e_valid = 1; e_code = c;
            e_bank = (c == 5) ? 2'd0 : b;
            e_col = (c == 2 || c == 3) ? a[CW-1:0] : '0;
            e_err = (c == 2 || c == 3) && !m_act[b];
            e_row = (c == 1) ? a : (c == 2 || c == 3) ? m_row[b] : 12'd0;
            if (c == 1) begin m_act[b] = 1; m_row[b] = a; end
            if (c == 4) begin
                if (a[10]) m_act = '0; else m_act[b] = 0;
            end
        end else begin
            e_valid = 0; e_err = 0;
        end
        e_pdown = !k && (m_act == 0);
        m_cke_q = k;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) m_row[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare("R12 reset state");

        // R2: select high, every pattern, bank and a few addresses ignored
        for (int p = 0; p < 8; p++)
            for (int b = 0; b < 4; b++)
                step("R2 deselect ignored", 1'b1, 3'(p), 1'b1, 2'(b), 12'(p * 300 + b));

        // R4: open every bank with its own row
        for (int b = 0; b < 4; b++)
            step("R4 open bank", 1'b0, 3'b011, 1'b1, 2'(b), 12'(12'h0A5 + b * 12'h311));

        // R5: read and write each bank, column truncated to COL_W
        for (int b = 0; b < 4; b++) begin
            step("R5 read column", 1'b0, 3'b101, 1'b1, 2'(b), 12'(b * 37 + 12'hE00));
            step("R5 write column", 1'b0, 3'b100, 1'b1, 2'(b), 12'hFFF);
            step("R1 idle cycle holds fields", 1'b0, 3'b111, 1'b1, 2'(b), 12'h123);
        end

        // R3: every pattern with select low, on each bank
        for (int b = 0; b < 4; b++)
            for (int p = 7; p >= 0; p--)
                step("R3 decode sweep", 1'b0, 3'(p), 1'b1, 2'(b), 12'(p * 91 + b * 5));

        // R6: refresh and mode set fields
        step("R6 refresh", 1'b0, 3'b001, 1'b1, 2'd3, 12'h7FF);
        step("R6 mode set", 1'b0, 3'b000, 1'b1, 2'd2, 12'h033);

        // R7 / R8: single close, access to idle bank, close all
        for (int b = 0; b < 4; b++)
            step("R4 reopen", 1'b0, 3'b011, 1'b1, 2'(b), 12'(b * 12'h101));
        step("R7 close one", 1'b0, 3'b010, 1'b1, 2'd1, 12'h000);
        step("R8 read idle bank", 1'b0, 3'b101, 1'b1, 2'd1, 12'h011);
        step("R8 write open bank", 1'b0, 3'b100, 1'b1, 2'd2, 12'h012);
        step("R7 close all", 1'b0, 3'b010, 1'b1, 2'd0, 12'h400);
        step("R8 write idle bank", 1'b0, 3'b100, 1'b1, 2'd3, 12'h013);

        // R9 / R11: clock suspend with a bank open
        step("R4 open for suspend", 1'b0, 3'b011, 1'b1, 2'd0, 12'h555);
        step("R9 read on enable-low edge", 1'b0, 3'b101, 1'b0, 2'd0, 12'h021);
        step("R9 open ignored", 1'b0, 3'b011, 1'b0, 2'd3, 12'h0AA);
        step("R9 close all ignored", 1'b0, 3'b010, 1'b0, 2'd0, 12'h400);
        step("R11 enable back, edge still frozen", 1'b0, 3'b011, 1'b1, 2'd3, 12'h0BB);
        step("R11 command accepted", 1'b0, 3'b011, 1'b1, 2'd3, 12'h0CC);

        // R10: power-down entered by closing all on the enable-low edge
        step("R10 close all, enable low", 1'b0, 3'b010, 1'b0, 2'd0, 12'h400);
        for (int i = 0; i < 4; i++)
            step("R10 power-down held", 1'b0, 3'b011, 1'b0, 2'(i), 12'h0DD);
        step("R11 exit power-down", 1'b0, 3'b011, 1'b1, 2'd1, 12'h0EE);
        step("R11 accepted after exit", 1'b0, 3'b011, 1'b1, 2'd1, 12'h0F0);

        // R10: open on the enable-low edge gives suspend, not power-down
        step("R7 close all", 1'b0, 3'b010, 1'b1, 2'd0, 12'h400);
        step("R10 open on enable-low edge", 1'b0, 3'b011, 1'b0, 2'd2, 12'h321);
        step("R9 suspended not powered down", 1'b0, 3'b101, 1'b1, 2'd2, 12'h004);
        step("R11 read after suspend", 1'b0, 3'b101, 1'b1, 2'd2, 12'h005);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule